// File: doc/BRIEF.md
# Multicast Tree Routing Table

This block sits at one input port of a five-port 2-D mesh router and decides which outputs the flit at the head of that port's buffer must go to. Plain unicast flits get a dimension-ordered route: first along X, then along Y. Tree-building setup flits are routed the same way. The output bit chosen for a setup flit is also merged into a routing table entry selected by the flit's source node and tree number. Later multicast flits that carry the same source and tree number replay the merged vector. A single buffered flit can then fork to several outputs without the source sending copies.

The table only steers flits. It holds no buffers and reserves no channels. The block presents a request vector to an external switch allocator. Each branch is granted on its own, and a granted branch drops out of the request while the rest keep waiting. The flit stays in the buffer until every branch has been served. Table storage is split evenly across the source nodes, with a fixed number of trees per source.

Top module: `mtree_route`

## Requirements
- R1: After reset, `in_ready_o` is 1, `req_o` is 0 and `done_o` is 0, and every table entry is empty.
- R2: Node identifiers are `y*MESH_X + x`. Output bits are: 0 eject, 1 North (smaller y), 2 South (larger y), 3 East (larger x), 4 West (smaller x). A unicast flit (kind 0, or the unused kind 3) requests exactly one output. That output is East or West while the destination x differs from the router's own x. Otherwise it is South or North while the y values differ. Otherwise it is eject.
- R3: A setup flit (kind 1) requests the same single output as a unicast flit to the same destination. That bit is OR-ed into the table entry for its (source, tree) pair.
- R4: A setup flit with `in_first_i` set empties its entry before OR-ing in its bit, so it replaces an older tree.
- R5: A multicast flit (kind 2) requests every output bit held in the entry for its (source, tree) pair. Entries for different sources or different tree numbers do not affect one another.
- R6: A grant on a requested output removes only that output from `req_o` on the next cycle. `done_o` stays 0 while other outputs are still requested.
- R7: `done_o` is 1 in the cycle in which the last remaining requested output is granted. On the next cycle `req_o` is 0 and `in_ready_o` is 1.
- R8: A multicast flit whose entry is empty is accepted with `done_o` at 1 in the same cycle, and it requests nothing.
- R9: While any output is requested, `in_ready_o` is 0 and a presented flit is not taken. Grants on outputs that are not requested have no effect.
- R10: Unicast flits never change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Head flit present |
| in_kind_i | input | 2 | 0 unicast, 1 setup, 2 multicast, 3 treated as unicast |
| in_first_i | input | 1 | Setup flit starts a new tree |
| in_src_i | input | NODE_W | Source node of the flit |
| in_tree_i | input | TREE_W | Tree number within the source's share |
| in_dst_i | input | NODE_W | Destination node (unicast and setup) |
| in_ready_o | output | 1 | Flit is taken this cycle when valid |
| req_o | output | 5 | Outputs still requested by the held flit |
| gnt_i | input | 5 | Per-output grants from the allocator |
| done_o | output | 1 | Held flit fully served, buffer slot freed |

## Verification
The hardest state to reach is a branch point that is only partly served: a multicast flit holding three or more outputs, with some of them granted and the others still pending. To get there, the stimulus first builds a tree from four setup flits, each aimed at a destination that leaves through a different output of the router at (1,1). It then grants one branch at a time while a competing flit and stray grants are presented. Tree replacement is driven by a later setup flit with the first flag set. The surviving vector is checked against the bench's own X-Y model.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int NPORT = 5;
  localparam int P_EJ = 0;
  localparam int P_N  = 1;
  localparam int P_S  = 2;
  localparam int P_E  = 3;
  localparam int P_W  = 4;
  localparam logic [1:0] K_SETUP = 2'd1;
  localparam logic [1:0] K_MCAST = 2'd2;
endpackage

// File: rtl/mtr_xy_route.sv
module mtr_xy_route
  import mtr_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int NODE_W = 4
) (
  input  logic [NODE_W-1:0] dst_i,
  output logic [NPORT-1:0]  port_o
);
  int dx, dy;
  always_comb begin
    dx = int'(dst_i) % MESH_X;
    dy = int'(dst_i) / MESH_X;
    port_o = '0;
    if (dx > MY_X)      port_o[P_E]  = 1'b1;
    else if (dx < MY_X) port_o[P_W]  = 1'b1;
    else if (dy > MY_Y) port_o[P_S]  = 1'b1;
    else if (dy < MY_Y) port_o[P_N]  = 1'b1;
    else                port_o[P_EJ] = 1'b1;
  end
endmodule

// File: rtl/mtr_tree_table.sv
module mtr_tree_table
  import mtr_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int TREES  = 4,
  parameter int NODE_W = 4,
  parameter int TREE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_clear_i,
  input  logic [NODE_W-1:0] src_i,
  input  logic [TREE_W-1:0] tree_i,
  input  logic [NPORT-1:0]  wr_bits_i,
  output logic [NPORT-1:0]  rd_bits_o
);
  localparam int ENTRIES = NODES * TREES;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [NPORT-1:0] tbl_q [ENTRIES];
  logic [IDX_W-1:0] idx;

  // static equal split: each source owns TREES consecutive entries
  assign idx       = IDX_W'((int'(src_i) % NODES) * TREES + int'(tree_i) % TREES);
  assign rd_bits_o = tbl_q[idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[e] <= '0;
      else if (wr_en_i && idx == IDX_W'(e))
        tbl_q[e] <= (wr_clear_i ? '0 : tbl_q[e]) | wr_bits_i;
    end
  end
endmodule

// File: rtl/mtr_branch_track.sv
module mtr_branch_track
  import mtr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NPORT-1:0] vec_i,
  input  logic [NPORT-1:0] gnt_i,
  output logic [NPORT-1:0] rem_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [NPORT-1:0] rem_q, left;

  assign left   = rem_q & ~gnt_i;
  assign busy_o = |rem_q;
  assign done_o = busy_o && (left == '0);
  assign rem_o  = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= vec_i;
    else if (busy_o) rem_q <= left;
  end
endmodule

// File: rtl/mtree_route.sv
module mtree_route
  import mtr_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int TREES  = 4,
  localparam int NODES  = MESH_X * MESH_Y,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int TREE_W = (TREES > 1) ? $clog2(TREES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        in_kind_i,
  input  logic              in_first_i,
  input  logic [NODE_W-1:0] in_src_i,
  input  logic [TREE_W-1:0] in_tree_i,
  input  logic [NODE_W-1:0] in_dst_i,
  output logic              in_ready_o,
  output logic [4:0]        req_o,
  input  logic [4:0]        gnt_i,
  output logic              done_o
);
  logic [NPORT-1:0] xy_vec, tbl_vec, route_vec;
  logic accept, busy, trk_done, is_mcast, is_setup;

  assign is_mcast   = (in_kind_i == K_MCAST);
  assign is_setup   = (in_kind_i == K_SETUP);
  assign in_ready_o = !busy;
  assign accept     = in_valid_i && !busy;
  assign route_vec  = is_mcast ? tbl_vec : xy_vec;

  mtr_xy_route #(
    .MESH_X(MESH_X), .MY_X(MY_X), .MY_Y(MY_Y), .NODE_W(NODE_W)
  ) u_xy (
    .dst_i (in_dst_i),
    .port_o(xy_vec)
  );

  mtr_tree_table #(
    .NODES(NODES), .TREES(TREES), .NODE_W(NODE_W), .TREE_W(TREE_W)
  ) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept && is_setup),
    .wr_clear_i(in_first_i),
    .src_i     (in_src_i),
    .tree_i    (in_tree_i),
    .wr_bits_i (xy_vec),
    .rd_bits_o (tbl_vec)
  );

  mtr_branch_track u_trk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .vec_i (route_vec),
    .gnt_i (gnt_i),
    .rem_o (req_o),
    .busy_o(busy),
    .done_o(trk_done)
  );

  // empty tree: nothing to send, slot freed at once
  assign done_o = trk_done || (accept && route_vec == '0);
endmodule

// File: rtl/mtree_route_chk.sv
module mtree_route_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [1:0] in_kind_i,
  input logic       in_ready_o,
  input logic [4:0] req_o,
  input logic [4:0] gnt_i,
  input logic       done_o
);
  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == (req_o == 5'd0));

  // R9
  no_new_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> (req_o & ~$past(req_o)) == 5'd0);

  // R6
  gnt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_o & gnt_i) != 5'd0) |=> (req_o & $past(req_o & gnt_i)) == 5'd0);

  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> in_ready_o);

  // R2
  uni_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_kind_i != 2'd2) |=> $countones(req_o) == 1);
endmodule

bind mtree_route mtree_route_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_kind_i (in_kind_i),
  .in_ready_o(in_ready_o),
  .req_o     (req_o),
  .gnt_i     (gnt_i),
  .done_o    (done_o)
);

// File: tb/mtree_route_test.sv
`timescale 1ns/1ps
module mtree_route_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [1:0] in_kind_i = '0;
  logic       in_first_i = 1'b0;
  logic [3:0] in_src_i = '0;
  logic [1:0] in_tree_i = '0;
  logic [3:0] in_dst_i = '0;
  logic       in_ready_o, done_o;
  logic [4:0] req_o;
  logic [4:0] gnt_i = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mtree_route uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_kind_i(in_kind_i),
    .in_first_i(in_first_i), .in_src_i(in_src_i), .in_tree_i(in_tree_i),
    .in_dst_i(in_dst_i), .in_ready_o(in_ready_o), .req_o(req_o), .gnt_i(gnt_i),
    .done_o(done_o)
  );

  // X-Y model of router (1,1) on a 4x4 mesh
  function automatic logic [4:0] xy_ref(int dst);
    int x = dst % 4, y = dst / 4;
    if (x > 1) return 5'b01000;
    if (x < 1) return 5'b10000;
    if (y > 1) return 5'b00100;
    if (y < 1) return 5'b00010;
    return 5'b00001;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // present one flit from a negedge, leave at the following negedge
  task automatic send(logic [1:0] k, logic f, int src, int tr, int dst);
    in_valid_i = 1'b1; in_kind_i = k; in_first_i = f;
    in_src_i = 4'(src); in_tree_i = 2'(tr); in_dst_i = 4'(dst);
    @(posedge clk); @(negedge clk);
    in_valid_i = 1'b0; in_first_i = 1'b0;
  endtask

  // grant everything requested and confirm release
  task automatic drain(string rq);
    gnt_i = req_o; #1;
    chk(rq, done_o, 1);
    @(posedge clk); @(negedge clk);
    gnt_i = '0;
    chk(rq, {in_ready_o, req_o}, {1'b1, 5'd0});
  endtask

  task automatic t_reset;
    chk("R1 ready", in_ready_o, 1);
    chk("R1 req", req_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_unicast;
    int dl[6] = '{0, 15, 9, 1, 5, 13};
    foreach (dl[i]) begin
      send(2'd0, 1'b0, 2, 0, dl[i]);
      chk("R2 unicast route", req_o, xy_ref(dl[i]));
      drain("R7 unicast release");
    end
    send(2'd3, 1'b0, 2, 0, 4);
    chk("R2 kind3 as unicast", req_o, xy_ref(4));
    drain("R7 kind3 release");
  endtask

  task automatic t_empty;
    in_valid_i = 1'b1; in_kind_i = 2'd2; in_src_i = 4'd3; in_tree_i = 2'd1; #1;
    chk("R8 empty done", done_o, 1);
    chk("R8 empty ready", in_ready_o, 1);
    @(posedge clk); @(negedge clk);
    in_valid_i = 1'b0;
    chk("R8 empty no req", req_o, 0);
  endtask

  task automatic t_build_partial;
    int dl[4] = '{6, 9, 5, 4};
    foreach (dl[i]) begin
      send(2'd1, i == 0, 0, 2, dl[i]);
      chk("R3 setup forwards", req_o, xy_ref(dl[i]));
      drain("R3 setup release");
    end
    send(2'd2, 1'b0, 0, 2, 0);
    chk("R5 tree vector", req_o, 5'b11101);
    chk("R9 busy not ready", in_ready_o, 0);
    gnt_i = 5'b01000; #1;
    chk("R6 partial no done", done_o, 0);
    // competing flit while busy
    in_valid_i = 1'b1; in_kind_i = 2'd0; in_dst_i = 4'd1;
    @(posedge clk); @(negedge clk);
    gnt_i = '0;
    chk("R6 east cleared", req_o, 5'b10101);
    chk("R9 competing flit ignored", in_ready_o, 0);
    in_valid_i = 1'b0;
    gnt_i = 5'b01010; #1;   // bits not requested
    chk("R9 stray grant no done", done_o, 0);
    @(posedge clk); @(negedge clk);
    gnt_i = '0;
    chk("R9 stray grant no effect", req_o, 5'b10101);
    gnt_i = 5'b00100;
    @(posedge clk); @(negedge clk);
    gnt_i = '0;
    chk("R6 south cleared", req_o, 5'b10001);
    drain("R7 last branch");
  endtask

  task automatic t_isolation;
    t_empty_at(1, 2, "R5 other source empty");
    t_empty_at(0, 1, "R5 other tree empty");
    send(2'd0, 1'b0, 0, 2, 15);
    drain("R10 unicast release");
    send(2'd2, 1'b0, 0, 2, 0);
    chk("R10 table unchanged by unicast", req_o, 5'b11101);
    drain("R10 release");
  endtask

  task automatic t_empty_at(int src, int tr, string rq);
    in_valid_i = 1'b1; in_kind_i = 2'd2; in_src_i = 4'(src); in_tree_i = 2'(tr); #1;
    chk(rq, {done_o, in_ready_o}, 2'b11);
    @(posedge clk); @(negedge clk);
    in_valid_i = 1'b0;
    chk(rq, req_o, 0);
  endtask

  task automatic t_replace;
    send(2'd1, 1'b1, 0, 2, 1);
    chk("R4 setup route", req_o, 5'b00010);
    drain("R4 setup release");
    send(2'd2, 1'b0, 0, 2, 0);
    chk("R4 replaced vector", req_o, 5'b00010);
    drain("R4 release");
    send(2'd1, 1'b0, 0, 2, 0);
    drain("R3 add west");
    send(2'd2, 1'b0, 0, 2, 0);
    chk("R3 merged vector", req_o, 5'b10010);
    drain("R3 release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_unicast;
    t_empty;
    t_build_partial;
    t_isolation;
    t_replace;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule